// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the bus-facing half of a 512-byte word-addressed nonvolatile memory. It watches a two-wire serial bus (I2C-style clock and data), sampled in the system clock domain. It finds start and stop conditions and decodes three kinds of control word: a write-select that also carries address bit 8, a word-address byte, and a read-select. It answers each accepted byte with an acknowledge. It streams data bytes back to the master from an internal address counter.

The data line is open-drain. The block has no tristate driver. It raises `sda_pull` whenever the line must be driven low.

Toward the memory core, the block presents:
- the current word address, used both for reading the array and as the program target;
- the data byte that was received;
- a one-cycle program request, raised when a complete write ends with a stop.

A separate programming sequencer reports back through `prog_busy`. While that input is high, read-selects go unanswered, and a write-select raises a one-cycle abort request.

Top module: `nvm_i2c_engine`

## Requirements
- R1: After reset, `sda_pull`, `prog_req` and `abort_req` are low and `word_addr` is 0.
- R2: A fall of SDA while SCL is high is a start, and a rise of SDA while SCL is high is a stop. A start at any bit position restarts reception of a control word at its first bit.
- R3: A control word is honoured only if bits 7..4 equal 1010 and bit 1 equals `cs_sel`. Bit 0 = 0 with bit 3 = 0 means write-select, with bit 2 as address bit 8. Bit 0 = 1 means read-select. Any other byte gets no acknowledge, and SDA stays released until the next start.
- R4: For every accepted byte, the block pulls SDA low from the 8th SCL falling edge up to the 9th SCL falling edge, and releases it afterwards. The block changes `sda_pull` only after an SCL fall, a start or a stop.
- R5: After an acknowledged read-select, the byte at `word_addr` is sent MSB first. Each bit is driven after an SCL falling edge, starting with the falling edge that ends the acknowledge clock.
- R6: Start, write-select, address byte, data byte, then stop gives exactly one one-cycle `prog_req` pulse. At that pulse, `word_addr` = {A8, address byte} and `wr_data` = the data byte. A stop without a received data byte gives no pulse.
- R7: A master acknowledge (SDA low on the 9th clock of a read byte) advances `word_addr` by one and sends the next byte. A master non-acknowledge ends output, so SDA stays released for further clocks. A stop always releases SDA.
- R8: A read-select that is not preceded by an address write reads from the address currently held.
- R9: At address 511 the counter saturates: further master acknowledges keep returning the byte at 511.
- R10: While `prog_busy` is high, a read-select is not acknowledged.
- R11: While `prog_busy` is high, a write-select is acknowledged and `abort_req` pulses for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| cs_sel | input | 1 | Chip-select strap compared against control word bit 1 |
| prog_busy | input | 1 | Programming sequencer is active |
| rd_data | input | 8 | Array byte at `word_addr` |
| sda_pull | output | 1 | Drive the data line low (open-drain enable) |
| word_addr | output | 9 | Current word address |
| wr_data | output | 8 | Last received data byte |
| prog_req | output | 1 | One-cycle request to program `wr_data` at `word_addr` |
| abort_req | output | 1 | One-cycle request to stop an active program cycle |

## Verification
The engine is driven with several control-word patterns:
- a matching write-select and a matching read-select, which separate the acknowledge paths from the data-out path;
- a write-select whose chip-select bit disagrees with the strap, and a byte with a wrong tag, which show that decode rejects both;
- a control word cut off after three bits by a repeated start, which shows the bit counter restarts.

Read streams are tried three ways:
- starting at an address loaded by a write, which exercises the increment;
- with no address write, which shows the held address is reused;
- starting at 511, which separates saturation from wrap-around.

The busy input is raised around both select types, which shows read refusal apart from write abort.

// File: rtl/nvm_i2c_pkg.sv
package nvm_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W + 1;
  localparam logic [3:0] DEV_TAG = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_WADDR,
    PH_WDATA,
    PH_RDATA,
    PH_WAIT
  } phase_t;
endpackage

// File: rtl/nvm_bus_sampler.sv
module nvm_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign ev_start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/nvm_addr_ctr.sv
module nvm_addr_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] addr
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] addr_d;

  always_comb begin
    addr_d = addr;
    if (ld)                     addr_d = ld_val;
    else if (inc && addr != TOP) addr_d = addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr <= '0;
    else if (ld || inc) addr <= addr_d;
  end
endmodule

// File: rtl/nvm_i2c_engine.sv
module nvm_i2c_engine
  import nvm_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              cs_sel,
  input  logic              prog_busy,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_pull,
  output logic [ADDR_W-1:0] word_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              prog_req,
  output logic              abort_req
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic sda_s, scl_rise, scl_fall, ev_start, ev_stop;

  nvm_bus_sampler #(.STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  logic              addr_ld, addr_inc;
  logic [ADDR_W-1:0] addr_val;

  nvm_addr_ctr #(.W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld(addr_ld), .ld_val(addr_val),
    .inc(addr_inc), .addr(word_addr)
  );

  phase_t            ph_q, ph_d, nxt_q, nxt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d, wd_q, wd_d, byte_in;
  logic oe_q, oe_d, ack_q, ack_d, a8_q, a8_d, arm_q, arm_d;
  logic prog_q, prog_d, abort_q, abort_d;

  assign byte_in = {rx_q, sda_s};

  always_comb begin
    ph_d = ph_q; nxt_d = nxt_q; cnt_d = cnt_q; rx_d = rx_q; tx_d = tx_q;
    wd_d = wd_q; oe_d = oe_q; ack_d = ack_q; a8_d = a8_q; arm_d = arm_q;
    prog_d = 1'b0; abort_d = 1'b0;
    addr_ld = 1'b0; addr_inc = 1'b0; addr_val = {a8_q, byte_in};
    if (ev_stop) begin
      ph_d = PH_IDLE; cnt_d = '0; oe_d = 1'b0; prog_d = arm_q; arm_d = 1'b0;
    end else if (ev_start) begin
      ph_d = PH_CTRL; cnt_d = '0; oe_d = 1'b0; arm_d = 1'b0; ack_d = 1'b0;
    end else if (scl_rise && ph_q != PH_IDLE) begin
      if (cnt_q == ACK_SLOT) begin
        cnt_d = '0;
        ack_d = 1'b0;
        if (ph_q == PH_RDATA) begin
          if (sda_s) ph_d = PH_WAIT;
          else       addr_inc = 1'b1;
        end else begin
          ph_d = nxt_q;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
        rx_d  = byte_in[BYTE_W-2:0];
        if (cnt_q == LAST_BIT && ph_q != PH_RDATA) begin
          ack_d = 1'b0;
          nxt_d = PH_WAIT;
          case (ph_q)
            PH_CTRL: begin
              if (byte_in[7:4] == DEV_TAG && byte_in[1] == cs_sel) begin
                if (!byte_in[0] && !byte_in[3]) begin
                  ack_d = 1'b1; nxt_d = PH_WADDR; a8_d = byte_in[2];
                  abort_d = prog_busy;
                end else if (byte_in[0] && !prog_busy) begin
                  ack_d = 1'b1; nxt_d = PH_RDATA;
                end
              end
            end
            PH_WADDR: begin
              ack_d = 1'b1; nxt_d = PH_WDATA; addr_ld = 1'b1;
            end
            PH_WDATA: begin
              ack_d = 1'b1; nxt_d = PH_WAIT; wd_d = byte_in; arm_d = 1'b1;
            end
            default: ;
          endcase
        end
      end
    end else if (scl_fall) begin
      if (cnt_q == ACK_SLOT) begin
        oe_d = (ph_q == PH_RDATA) ? 1'b0 : ack_q;
      end else if (ph_q == PH_RDATA) begin
        if (cnt_q == '0) begin
          oe_d = ~rd_data[BYTE_W-1];
          tx_d = {rd_data[BYTE_W-2:0], 1'b1};
        end else begin
          oe_d = ~tx_q[BYTE_W-1];
          tx_d = {tx_q[BYTE_W-2:0], 1'b1};
        end
      end else begin
        oe_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; nxt_q <= PH_WAIT; cnt_q <= '0; rx_q <= '0; tx_q <= '1;
      wd_q <= '0; oe_q <= 1'b0; ack_q <= 1'b0; a8_q <= 1'b0; arm_q <= 1'b0;
      prog_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      ph_q <= ph_d; nxt_q <= nxt_d; cnt_q <= cnt_d; rx_q <= rx_d; tx_q <= tx_d;
      wd_q <= wd_d; oe_q <= oe_d; ack_q <= ack_d; a8_q <= a8_d; arm_q <= arm_d;
      prog_q <= prog_d; abort_q <= abort_d;
    end
  end

  assign sda_pull  = oe_q;
  assign wr_data   = wd_q;
  assign prog_req  = prog_q;
  assign abort_req = abort_q;
endmodule

// File: rtl/nvm_i2c_engine_chk.sv
module nvm_i2c_engine_chk #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_pull,
  input logic          prog_req,
  input logic          abort_req,
  input logic          prog_busy,
  input logic [AW-1:0] word_addr,
  input logic          scl_fall,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          addr_ld
);
  AST_PROG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req); // R6

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req); // R11

  AST_ABORT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_req) |-> $past(prog_busy)); // R11

  AST_PULL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || ev_start || ev_stop)); // R4

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_pull); // R7

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(word_addr) && !$past(addr_ld)) |-> (word_addr == $past(word_addr) + 1'b1)); // R7

  AST_ADDR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_addr == '1 && !addr_ld) |=> (word_addr == '1)); // R9
endmodule

bind nvm_i2c_engine nvm_i2c_engine_chk #(.AW(nvm_i2c_pkg::ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .prog_req(prog_req),
  .abort_req(abort_req), .prog_busy(prog_busy), .word_addr(word_addr),
  .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop), .addr_ld(addr_ld)
);

// File: tb/tb_nvm_i2c_engine.sv
module tb_nvm_i2c_engine;
  localparam int Q = 6;

  logic clk, rst_n, scl, sda_m, cs_sel, busy;
  logic [7:0] rd_data, wr_data;
  logic [8:0] word_addr;
  logic sda_pull, prog_req, abort_req, sda_line;
  int tests, fails, prog_cnt, abort_cnt;
  logic [8:0] prog_addr;
  logic [7:0] prog_data;
  bit done;

  function automatic logic [7:0] mem_f(input logic [8:0] a);
    return a[7:0] ^ (a[8] ? 8'h3C : 8'hC3);
  endfunction

  assign sda_line = sda_m & ~sda_pull;
  assign rd_data  = mem_f(word_addr);

  nvm_i2c_engine dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .cs_sel(cs_sel),
    .prog_busy(busy), .rd_data(rd_data), .sda_pull(sda_pull),
    .word_addr(word_addr), .wr_data(wr_data), .prog_req(prog_req),
    .abort_req(abort_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (prog_req) begin
      prog_cnt++; prog_addr = word_addr; prog_data = wr_data;
    end
    if (abort_req) abort_cnt++;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked, output bit freed);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    acked = (sda_line == 1'b0);
    tick(Q); scl = 1'b0; tick(Q);
    freed = (sda_pull == 1'b0);
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
    end
    tick(Q); sda_m = ~mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] wsel(bit a8, bit cs);
    return {4'b1010, 1'b0, a8, cs, 1'b0};
  endfunction
  function automatic logic [7:0] rsel(bit cs);
    return {4'b1010, 2'b00, cs, 1'b1};
  endfunction

  task automatic t_reset;
    check(sda_pull == 0, "R1 sda_pull", sda_pull, 0);
    check(prog_req == 0 && abort_req == 0, "R1 strobes", {prog_req, abort_req}, 0);
    check(word_addr == 0, "R1 word_addr", word_addr, 0);
  endtask

  task automatic t_write;
    bit a1, a2, a3, f1, f2, f3;
    int p0 = prog_cnt;
    cs_sel = 1'b0;
    bus_start;
    send_byte(wsel(1'b1, 1'b0), a1, f1);
    send_byte(8'h23, a2, f2);
    send_byte(8'h5E, a3, f3);
    check(a1 && a2 && a3, "R4 acks on write bytes", {a1, a2, a3}, 7);
    check(f1 && f2 && f3, "R4 release after ack", {f1, f2, f3}, 7);
    bus_stop;
    check(prog_cnt == p0 + 1, "R6 prog pulse count", prog_cnt - p0, 1);
    check(prog_addr == 9'h123, "R6 program address", prog_addr, 9'h123);
    check(prog_data == 8'h5E, "R6 program data", prog_data, 8'h5E);
  endtask

  task automatic t_reject;
    bit a1, a2, f;
    int p0 = prog_cnt;
    cs_sel = 1'b1;
    bus_start;
    send_byte(wsel(1'b0, 1'b0), a1, f);
    send_byte(8'h40, a2, f);
    check(!a1 && !a2, "R3 chip-select mismatch not acked", {a1, a2}, 0);
    bus_stop;
    check(prog_cnt == p0, "R3 no program after mismatch", prog_cnt - p0, 0);
    bus_start;
    send_byte(8'h92, a1, f);
    check(!a1, "R3 wrong tag not acked", a1, 0);
    bus_stop;
    cs_sel = 1'b0;
  endtask

  task automatic t_read;
    bit a, f;
    logic [7:0] d;
    bus_start;
    send_byte(wsel(1'b0, 1'b0), a, f);
    send_byte(8'h10, a, f);
    bus_start;
    send_byte(rsel(1'b0), a, f);
    check(a, "R4 read-select acked", a, 1);
    read_byte(1'b1, d);
    check(d == mem_f(9'h010), "R5 first read byte", d, mem_f(9'h010));
    read_byte(1'b1, d);
    check(d == mem_f(9'h011), "R7 incremented byte", d, mem_f(9'h011));
    read_byte(1'b0, d);
    check(d == mem_f(9'h012), "R7 third byte", d, mem_f(9'h012));
    check(sda_pull == 0, "R7 released after nack", sda_pull, 0);
    read_byte(1'b0, d);
    check(d == 8'hFF, "R7 no output after nack", d, 8'hFF);
    bus_stop;
    check(sda_pull == 0, "R7 released after stop", sda_pull, 0);
    bus_start;
    send_byte(rsel(1'b0), a, f);
    read_byte(1'b0, d);
    check(d == mem_f(9'h012), "R8 shortened read", d, mem_f(9'h012));
    check(word_addr == 9'h012, "R8 held address", word_addr, 9'h012);
    bus_stop;
  endtask

  task automatic t_saturate;
    bit a, f;
    logic [7:0] d;
    bus_start;
    send_byte(wsel(1'b1, 1'b0), a, f);
    send_byte(8'hFF, a, f);
    bus_start;
    send_byte(rsel(1'b0), a, f);
    for (int k = 0; k < 3; k++) begin
      read_byte(k != 2, d);
      check(d == mem_f(9'h1FF), "R9 saturated read", d, mem_f(9'h1FF));
    end
    check(word_addr == 9'h1FF, "R9 address stays 511", word_addr, 9'h1FF);
    bus_stop;
  endtask

  task automatic t_busy;
    bit a, f;
    int p0 = prog_cnt;
    int b0 = abort_cnt;
    busy = 1'b1;
    bus_start;
    send_byte(rsel(1'b0), a, f);
    check(!a, "R10 read-select refused while busy", a, 0);
    bus_stop;
    check(abort_cnt == b0, "R10 no abort on read-select", abort_cnt - b0, 0);
    bus_start;
    send_byte(wsel(1'b0, 1'b0), a, f);
    check(a, "R11 write-select acked while busy", a, 1);
    check(abort_cnt == b0 + 1, "R11 abort pulse", abort_cnt - b0, 1);
    bus_stop;
    check(prog_cnt == p0, "R6 no program without data", prog_cnt - p0, 0);
    busy = 1'b0;
  endtask

  task automatic t_restart;
    bit a1, a2, a3, f;
    int p0 = prog_cnt;
    bus_start;
    send_bits(8'hA0, 3);
    bus_start;
    send_byte(wsel(1'b0, 1'b0), a1, f);
    send_byte(8'h77, a2, f);
    send_byte(8'h0C, a3, f);
    check(a1 && a2 && a3, "R2 control word after mid-byte start", {a1, a2, a3}, 7);
    bus_stop;
    check(prog_cnt == p0 + 1 && prog_addr == 9'h077 && prog_data == 8'h0C,
          "R2 write after restart", prog_addr, 9'h077);
  endtask

  initial begin
    tests = 0; fails = 0; prog_cnt = 0; abort_cnt = 0; done = 0;
    scl = 1'b1; sda_m = 1'b1; cs_sel = 1'b0; busy = 1'b0; rst_n = 1'b0;
    tick(5);
    t_reset;
    rst_n = 1'b1;
    tick(5);
    t_write;
    t_reject;
    t_read;
    t_saturate;
    t_busy;
    t_restart;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule